// File: doc/BRIEF.md
# Framebuffer Fill and Copy Blitter

This block is a memory-mapped engine that fills or copies short horizontal runs of pixels in an 8-bit framebuffer and, when the deep mode is on, also in a companion 24-bit plane. Software uses a two-word protocol. It first writes a colour word. It then writes a command, where the bus address carries the destination pixel and the data word carries a source pixel and a run length.

If the source field is all ones, the engine paints the run with the colour that was latched. Any other source value makes it move the run from the source pixels to the destination pixels, one pixel at a time, in ascending order. The engine drives a single-port RAM interface that has a one-cycle read latency. It raises `busy` from the cycle after it accepts a command until the last write of that command. A command that arrives while the engine is busy is held off by deasserting `req_ready`.

Top module: `fb_blitter`

## Requirements
- R1: A full-word write with address bit 2 = 0 stores data bits 23:0 as the colour. It is accepted in every cycle, even while busy. A colour write made while busy does not change the run in progress; the next command uses it.
- R2: A full-word write with address bit 2 = 1 starts a command. The destination pixel index is address bits 22:3, the source index is data bits 23:0, and the run length is data bits 28:24 plus one.
- R3: When the source field is 0xFFFFFF, the engine writes colour bits 7:0 to the destination pixels in ascending order, one pixel per cycle. `busy` stays high for exactly one cycle per pixel.
- R4: For any other source value, each step reads source pixel i and then writes it to destination pixel i, taking two cycles per pixel. A forward copy whose runs overlap therefore propagates values as a series of ascending single-pixel moves.
- R5: If `depth24` = 1 when a command is accepted, the deep plane is updated at the same addresses and in the same cycles. A fill writes colour bits 23:0 there, and a copy copies deep words. If `depth24` = 0, the deep plane is never written.
- R6: `busy` rises in the cycle after a command is accepted. While `busy` is high, a command write sees `req_ready` = 0 and is held until the engine is idle, and it is not lost.
- R7: Reads return zero and start nothing.
- R8: A write whose byte enables are not all ones is accepted and ignored.
- R9: After reset the engine is idle, the colour is zero, `req_ready` is high and no RAM write is issued.
- R10: The run lengths at both ends of the range behave the same way: a field of 0 gives 1 pixel and a field of 31 gives 32 pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| depth24 | input | 1 | Deep-plane mode, sampled when a command is accepted |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address in the blitter window |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| req_rdata | output | 32 | Read data (always zero) |
| busy | output | 1 | Engine working |
| pix_addr | output | 20 | Pixel index for both planes |
| pix_we | output | 1 | 8-bit plane write enable |
| pix_wdata | output | 8 | 8-bit plane write data |
| pix_rdata | input | 8 | 8-bit plane read data, one cycle after the address |
| dp_we | output | 1 | Deep-plane write enable |
| dp_wdata | output | 24 | Deep-plane write data |
| dp_rdata | input | 24 | Deep-plane read data, one cycle after the address |

## Verification
A command accepted on clock edge E makes `busy` visible after E. `busy` then lasts L cycles for a fill and 2L cycles for a copy, so the last RAM write lands on the edge where `busy` falls. The bench counts `busy` on falling edges after each accepted command and compares that count with L or 2L. It compares the whole memory against its own ascending-move model only after `busy` is low. Read data and `req_ready` are combinational, so they are sampled in the same cycle as the request. The signals checked for an ignored write are sampled one cycle after it.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_RD   = 2'd2,
      ST_WR   = 2'd3
   } fbb_state_e;
endpackage

// File: rtl/fbb_decode.sv
module fbb_decode #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32,
   parameter int PIX_AW = 20,
   parameter int SRC_W  = 24,
   parameter int LEN_W  = 5,
   parameter int DEEP_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W/8-1:0] req_be,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic                idle,
   output logic                req_ready,
   output logic [DATA_W-1:0]   req_rdata,
   output logic                cmd_go,
   output logic [PIX_AW-1:0]   cmd_dst,
   output logic [PIX_AW-1:0]   cmd_src,
   output logic [LEN_W-1:0]    cmd_len_m1,
   output logic                cmd_fill,
   output logic [DEEP_W-1:0]   colour_q
);
   localparam logic [SRC_W-1:0] FILL_CODE = '1;

   logic full_word, wr_ok, is_cmd;
   logic unused_bits;

   assign full_word = &req_be;
   assign wr_ok     = req_valid & req_write & full_word;
   assign is_cmd    = req_addr[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) colour_q <= '0;
      else if (wr_ok && !is_cmd) colour_q <= req_wdata[DEEP_W-1:0];
   end

   assign cmd_go     = wr_ok & is_cmd & idle;
   assign req_ready  = ~(wr_ok & is_cmd) | idle;
   assign req_rdata  = '0;
   assign cmd_dst    = req_addr[3 +: PIX_AW];
   assign cmd_src    = req_wdata[PIX_AW-1:0];
   assign cmd_len_m1 = req_wdata[SRC_W +: LEN_W];
   assign cmd_fill   = (req_wdata[SRC_W-1:0] == FILL_CODE);
   assign unused_bits = ^{req_addr, req_wdata};
endmodule

// File: rtl/fbb_seq.sv
module fbb_seq
   import fbb_pkg::*;
#(
   parameter int PIX_AW = 20,
   parameter int LEN_W  = 5,
   parameter int DEEP_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_go,
   input  logic [PIX_AW-1:0] cmd_dst,
   input  logic [PIX_AW-1:0] cmd_src,
   input  logic [LEN_W-1:0]  cmd_len_m1,
   input  logic              cmd_fill,
   input  logic [DEEP_W-1:0] colour_in,
   input  logic              depth24,
   output fbb_state_e        state,
   output logic [PIX_AW-1:0] dst_q,
   output logic [PIX_AW-1:0] src_q,
   output logic [DEEP_W-1:0] colour_q,
   output logic              m24_q,
   output logic              busy
);
   logic [LEN_W-1:0] cnt_q;
   logic             last;

   assign last = (cnt_q == '0);
   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         dst_q    <= '0;
         src_q    <= '0;
         cnt_q    <= '0;
         colour_q <= '0;
         m24_q    <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (cmd_go) begin
               dst_q    <= cmd_dst;
               src_q    <= cmd_src;
               cnt_q    <= cmd_len_m1;
               colour_q <= colour_in;
               m24_q    <= depth24;
               state    <= cmd_fill ? ST_FILL : ST_RD;
            end
            ST_FILL: begin
               dst_q <= dst_q + 1'b1;
               cnt_q <= cnt_q - 1'b1;
               if (last) state <= ST_IDLE;
            end
            ST_RD: begin
               src_q <= src_q + 1'b1;
               state <= ST_WR;
            end
            ST_WR: begin
               dst_q <= dst_q + 1'b1;
               cnt_q <= cnt_q - 1'b1;
               state <= last ? ST_IDLE : ST_RD;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fbb_port.sv
module fbb_port
   import fbb_pkg::*;
#(
   parameter int PIX_AW      = 20,
   parameter int PIX_W       = 8,
   parameter int DEEP_W      = 24,
   parameter bit HAS_PLANE24 = 1'b1
) (
   input  fbb_state_e        state,
   input  logic [PIX_AW-1:0] dst_q,
   input  logic [PIX_AW-1:0] src_q,
   input  logic [DEEP_W-1:0] colour_q,
   input  logic              m24_q,
   input  logic [PIX_W-1:0]  pix_rdata,
   input  logic [DEEP_W-1:0] dp_rdata,
   output logic [PIX_AW-1:0] pix_addr,
   output logic              pix_we,
   output logic [PIX_W-1:0]  pix_wdata,
   output logic              dp_we,
   output logic [DEEP_W-1:0] dp_wdata
);
   logic filling;

   assign filling   = (state == ST_FILL);
   assign pix_addr  = (state == ST_RD) ? src_q : dst_q;
   assign pix_we    = filling | (state == ST_WR);
   assign pix_wdata = filling ? colour_q[PIX_W-1:0] : pix_rdata;

   generate
      if (HAS_PLANE24) begin : g_deep
         assign dp_we    = pix_we & m24_q;
         assign dp_wdata = filling ? colour_q : dp_rdata;
      end else begin : g_flat
         logic unused_deep;
         assign dp_we       = 1'b0;
         assign dp_wdata    = '0;
         assign unused_deep = ^{m24_q, dp_rdata, colour_q};
      end
   endgenerate
endmodule

// File: rtl/fb_blitter.sv
module fb_blitter
   import fbb_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int DATA_W      = 32,
   parameter int PIX_AW      = 20,
   parameter int PIX_W       = 8,
   parameter int DEEP_W      = 24,
   parameter int SRC_W       = 24,
   parameter int LEN_W       = 5,
   parameter bit HAS_PLANE24 = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                depth24,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W/8-1:0] req_be,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                req_ready,
   output logic [DATA_W-1:0]   req_rdata,
   output logic                busy,
   output logic [PIX_AW-1:0]   pix_addr,
   output logic                pix_we,
   output logic [PIX_W-1:0]    pix_wdata,
   input  logic [PIX_W-1:0]    pix_rdata,
   output logic                dp_we,
   output logic [DEEP_W-1:0]   dp_wdata,
   input  logic [DEEP_W-1:0]   dp_rdata
);
   generate
      if (ADDR_W < PIX_AW + 3) begin : g_bad_addr
         $error("ADDR_W too small for destination field");
      end
      if (DATA_W < SRC_W + LEN_W || DATA_W < DEEP_W) begin : g_bad_data
         $error("DATA_W too small for command or colour");
      end
      if (SRC_W < PIX_AW || PIX_W > DEEP_W) begin : g_bad_pix
         $error("inconsistent pixel widths");
      end
   endgenerate

   logic              cmd_go, cmd_fill, m24_q;
   logic [PIX_AW-1:0] cmd_dst, cmd_src, dst_q, src_q;
   logic [LEN_W-1:0]  cmd_len_m1;
   logic [DEEP_W-1:0] colour_reg, colour_snap;
   fbb_state_e        state;

   fbb_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIX_AW(PIX_AW),
                .SRC_W(SRC_W), .LEN_W(LEN_W), .DEEP_W(DEEP_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .idle(!busy),
      .req_ready(req_ready), .req_rdata(req_rdata), .cmd_go(cmd_go),
      .cmd_dst(cmd_dst), .cmd_src(cmd_src), .cmd_len_m1(cmd_len_m1),
      .cmd_fill(cmd_fill), .colour_q(colour_reg));

   fbb_seq #(.PIX_AW(PIX_AW), .LEN_W(LEN_W), .DEEP_W(DEEP_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_dst(cmd_dst),
      .cmd_src(cmd_src), .cmd_len_m1(cmd_len_m1), .cmd_fill(cmd_fill),
      .colour_in(colour_reg), .depth24(depth24), .state(state),
      .dst_q(dst_q), .src_q(src_q), .colour_q(colour_snap), .m24_q(m24_q),
      .busy(busy));

   fbb_port #(.PIX_AW(PIX_AW), .PIX_W(PIX_W), .DEEP_W(DEEP_W),
              .HAS_PLANE24(HAS_PLANE24)) u_port (
      .state(state), .dst_q(dst_q), .src_q(src_q), .colour_q(colour_snap),
      .m24_q(m24_q), .pix_rdata(pix_rdata), .dp_rdata(dp_rdata),
      .pix_addr(pix_addr), .pix_we(pix_we), .pix_wdata(pix_wdata),
      .dp_we(dp_we), .dp_wdata(dp_wdata));
endmodule

// File: rtl/fbb_checker.sv
module fbb_checker #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 32,
   parameter int PIX_AW = 20,
   parameter int LEN_W  = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_write,
   input logic [ADDR_W-1:0]   req_addr,
   input logic [DATA_W/8-1:0] req_be,
   input logic                req_ready,
   input logic                busy,
   input logic [PIX_AW-1:0]   pix_addr,
   input logic                pix_we,
   input logic                dp_we
);
   localparam int MAX_BUSY = 2 << LEN_W;

   logic cmd_req;
   logic [LEN_W+2:0] busy_cnt;

   assign cmd_req = req_valid && req_write && req_addr[2] && (&req_be);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_cnt <= '0;
      else if (!busy) busy_cnt <= '0;
      else busy_cnt <= busy_cnt + 1'b1;
   end

   assert_write_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pix_we |-> busy);
   assert_deep_with_pixel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dp_we |-> pix_we);
   assert_stall_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_req) |-> !req_ready);
   assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_req) |=> busy);
   assert_ascending_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_we && $past(pix_we)) |-> (pix_addr == $past(pix_addr) + 1'b1));
   assert_run_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= MAX_BUSY[LEN_W+2:0]);
endmodule

bind fb_blitter fbb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIX_AW(PIX_AW),
                              .LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .req_be(req_be), .req_ready(req_ready), .busy(busy),
   .pix_addr(pix_addr), .pix_we(pix_we), .dp_we(dp_we));

// File: tb/tb_fb_blitter.sv
`timescale 1ns/1ps
module tb_fb_blitter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        depth24 = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [23:0] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, busy, pix_we, dp_we;
   logic [31:0] req_rdata;
   logic [19:0] pix_addr;
   logic [7:0]  pix_wdata, pix_rdata;
   logic [23:0] dp_wdata, dp_rdata;

   logic        pl_we = 1'b0;
   logic [11:0] pl_addr = '0;
   logic [7:0]  pl_d8 = '0;
   logic [23:0] pl_d24 = '0;

   logic [7:0]  mem8  [4096];
   logic [23:0] mem24 [4096];
   logic [7:0]  ref8  [4096];
   logic [23:0] ref24 [4096];

   int checks = 0, fails = 0;
   bit stall_seen;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   fb_blitter dut (.*);

   always_ff @(posedge clk) begin
      pix_rdata <= mem8[pix_addr[11:0]];
      dp_rdata  <= mem24[pix_addr[11:0]];
      if (pix_we) mem8[pix_addr[11:0]] <= pix_wdata;
      if (dp_we)  mem24[pix_addr[11:0]] <= dp_wdata;
      if (pl_we) begin
         mem8[pl_addr]  <= pl_d8;
         mem24[pl_addr] <= pl_d24;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cmp_mem(input string tag);
      int bad = 0;
      int first = -1;
      for (int i = 0; i < 4096; i++)
         if (mem8[i] !== ref8[i] || mem24[i] !== ref24[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      if (first < 0) chk(1'b1, tag, 0, 0);
      else chk(1'b0, $sformatf("%s pixel %0d", tag, first),
               {mem24[first], mem8[first]}, {ref24[first], ref8[first]});
   endtask

   task automatic bus_wr(input logic [23:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
      #1;
      while (!req_ready) begin
         stall_seen = 1'b1;
         @(negedge clk); #1;
      end
      @(posedge clk); #1;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   function automatic logic [31:0] cmd_data(input int src, input int len);
      return {3'b000, 5'(len - 1), 24'(src)};
   endfunction

   function automatic logic [23:0] cmd_addr(input int dst);
      return 24'((dst << 3) | 4);
   endfunction

   task automatic ref_apply(input int dst, input int src, input int len, input bit fill,
                            input logic [23:0] col, input bit m24);
      for (int i = 0; i < len; i++) begin
         if (fill) begin
            ref8[dst + i] = col[7:0];
            if (m24) ref24[dst + i] = col;
         end else begin
            ref8[dst + i] = ref8[src + i];
            if (m24) ref24[dst + i] = ref24[src + i];
         end
      end
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      @(negedge clk);
      while (busy) begin n++; @(negedge clk); end
   endtask

   task automatic run_op(input int dst, input int src, input int len, input bit fill,
                         input logic [23:0] col, input bit m24, input string tag);
      int n;
      depth24 = m24;
      bus_wr(24'h000000, {8'h5A, col}, 4'hF);
      bus_wr(cmd_addr(dst), cmd_data(fill ? 24'hFFFFFF : src, len), 4'hF);
      wait_idle(n);
      chk(n == (fill ? len : 2 * len), {tag, fill ? " R3 fill busy cycles" : " R4 copy busy cycles"},
          n, fill ? len : 2 * len);
      ref_apply(dst, src, len, fill, col, m24);
      cmp_mem({tag, " R2 R5 memory"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      void'($urandom(32'd9137));
      repeat (4) @(negedge clk);
      chk(busy == 1'b0, "R9 busy in reset", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && pix_we == 1'b0, "R9 idle after reset", {busy, pix_we}, 0);
      chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);

      for (int i = 0; i < 4096; i++) begin
         @(negedge clk);
         pl_we = 1'b1; pl_addr = 12'(i);
         pl_d8 = 8'($urandom); pl_d24 = 24'($urandom);
         ref8[i] = pl_d8; ref24[i] = pl_d24;
      end
      @(negedge clk); pl_we = 1'b0;

      // R9: colour is zero after reset; a fill without any colour write paints zero
      depth24 = 1'b1;
      bus_wr(cmd_addr(3000), cmd_data(24'hFFFFFF, 4), 4'hF);
      wait_idle(n);
      ref_apply(3000, 0, 4, 1'b1, 24'h0, 1'b1);
      cmp_mem("R9 reset colour zero");

      // R7: reads return zero and start nothing
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = cmd_addr(10); req_be = 4'hF;
      #1 chk(req_rdata == 32'h0 && req_ready, "R7 read data", req_rdata, 0);
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b0, "R7 read starts nothing", busy, 0);

      // R10 single pixel and full 32 pixel runs, R2 field decode
      run_op(100, 0, 1, 1'b1, 24'hA1B2C3, 1'b1, "R10 len1 fill");
      run_op(200, 0, 32, 1'b1, 24'h0F1E2D, 1'b1, "R10 len32 fill");
      run_op(300, 700, 32, 1'b0, 24'h0, 1'b1, "R10 len32 copy");
      run_op(400, 800, 1, 1'b0, 24'h0, 1'b0, "R10 len1 copy 8bit");

      // R4 overlapping forward copy propagates the first source pixel
      begin
         logic [7:0] seed8;
         seed8 = ref8[500];
         run_op(501, 500, 8, 1'b0, 24'h0, 1'b1, "R4 overlap");
         chk(mem8[508] == seed8, "R4 overlap propagation", mem8[508], seed8);
      end

      // R5 8-bit mode leaves deep plane alone
      run_op(600, 0, 16, 1'b1, 24'h777777, 1'b0, "R5 8bit fill");

      // R1 colour write while busy is accepted and does not disturb the run
      depth24 = 1'b1;
      bus_wr(24'h0, 32'h00112233, 4'hF);
      bus_wr(cmd_addr(1000), cmd_data(24'hFFFFFF, 32), 4'hF);
      stall_seen = 1'b0;
      bus_wr(24'h0, 32'h00445566, 4'hF);
      chk(busy == 1'b1 && !stall_seen, "R1 colour accepted while busy", {busy, stall_seen}, 2);
      wait_idle(n);
      ref_apply(1000, 0, 32, 1'b1, 24'h112233, 1'b1);
      cmp_mem("R1 run keeps old colour");
      bus_wr(cmd_addr(1100), cmd_data(24'hFFFFFF, 2), 4'hF);
      wait_idle(n);
      ref_apply(1100, 0, 2, 1'b1, 24'h445566, 1'b1);
      cmp_mem("R1 next run uses new colour");

      // R6 command while busy is stalled, then executed
      bus_wr(cmd_addr(1200), cmd_data(1500, 10), 4'hF);
      stall_seen = 1'b0;
      bus_wr(cmd_addr(1300), cmd_data(1210, 5), 4'hF);
      chk(stall_seen, "R6 ready low while busy", stall_seen, 1);
      chk(busy == 1'b1, "R6 stalled command started", busy, 1);
      wait_idle(n);
      ref_apply(1200, 1500, 10, 1'b0, 24'h0, 1'b1);
      ref_apply(1300, 1210, 5, 1'b0, 24'h0, 1'b1);
      cmp_mem("R6 both commands applied in order");

      // R8 partial writes ignored
      bus_wr(24'h0, 32'h00ABCDEF, 4'h7);
      bus_wr(cmd_addr(1400), cmd_data(24'hFFFFFF, 3), 4'h3);
      @(negedge clk);
      chk(busy == 1'b0, "R8 partial command ignored", busy, 0);
      cmp_mem("R8 memory untouched");
      bus_wr(cmd_addr(1400), cmd_data(24'hFFFFFF, 3), 4'hF);
      wait_idle(n);
      ref_apply(1400, 0, 3, 1'b1, 24'h445566, 1'b1);
      cmp_mem("R8 partial colour ignored");

      // random mix R2 R3 R4 R5
      for (int k = 0; k < 40; k++) begin
         bit f;
         int len, dst, src;
         f   = ($urandom % 3) == 0;
         len = int'($urandom % 32) + 1;
         dst = int'($urandom % 4000);
         src = int'($urandom % 4000);
         run_op(dst, src, len, f, 24'($urandom), 1'($urandom), $sformatf("rand%0d", k));
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule